// File: doc/BRIEF.md
# Sequential-Lookup Set-Associative Cache Controller

This block is a read cache controller that splits each lookup into two ordered steps. First it compares the tags of every way in the addressed set, all at once, in a cycle of its own. The data store is touched only after that step reports a hit, and then only the single matching way is read. A miss is sent to the next memory level in the same probe cycle and leaves the data store untouched. Fewer accesses to the large data store lower its switching activity and local temperature, which slows its wear. The cost is one extra cycle on each hit.

Requests come from a queue through a valid/ready pair, and the controller handles one request at a time. After a miss, the line returned from memory is written into a victim way, which a per-set round-robin pointer selects. The controller returns the filled line as the response. Three free-running counters report tag probes, data-store reads and misses, so that the effect of the filtering can be measured from outside the block.

Top module: `seqcache_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and all three counters read 0.
- R2: Only one request is in flight. `req_ready` drops in the cycle after a request is accepted. It stays low through the response cycle and returns high in the cycle after the response.
- R3: The cycle right after acceptance is the tag probe cycle. Each accepted request adds exactly 1 to `cnt_probe`, and no response appears in the probe cycle.
- R4: On a miss, `mem_req_valid` is high in the probe cycle and only then. `mem_req_addr` carries the line address, which is `req_addr` with its low log2(LINE_BYTES) bits dropped. `cnt_miss` rises by 1 and `cnt_data_rd` does not change.
- R5: On a hit, exactly one way of the data store is read, `cnt_data_rd` rises by 1 and no memory request is issued. `rsp_valid` is high for one cycle, first seen after the DATA_LAT-th rising edge that follows the accepting edge, and it carries the stored line.
- R6: While a miss waits, a one-cycle `fill_valid` stores the line and marks it valid. The next cycle returns `fill_data` as the response. A later request for the same line hits and returns the same data.
- R7: Each set has a round-robin victim pointer that starts at way 0 after reset and advances by one, wrapping, only on a fill into that set. A fill overwrites the way under the pointer. With WAYS ways, the (WAYS+1)-th distinct line filled into a set evicts the first one, so that line misses afterwards and the others still hit.
- R8: An invalid line never matches. After reset every stored tag is zero but invalid, so a request with tag 0 misses.
- R9: At every cycle, `cnt_data_rd + cnt_miss == cnt_probe` holds modulo 2^CNT_W, so data-store reads equal hits.
- R10: A fill into one set leaves the lines held in other sets valid, and they still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request available at the head of the input queue |
| req_ready | output | 1 | Controller idle; a request is taken when both are high |
| req_addr | input | ADDR_W | Byte address of the read request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | LINE_BYTES*8 | Returned cache line |
| mem_req_valid | output | 1 | One-cycle miss forward to the next memory level |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address of the missing request |
| fill_valid | input | 1 | Line returned from memory for the pending miss |
| fill_data | input | LINE_BYTES*8 | Returned line contents |
| cnt_probe | output | CNT_W | Number of tag probes |
| cnt_data_rd | output | CNT_W | Number of data-store reads |
| cnt_miss | output | CNT_W | Number of misses |

## Verification
The bench builds the controller with 4 ways, 4 sets, 4-byte lines, 16-bit addresses and 16-bit counters. It keeps the data-store latency at its default of 5, so the hit-latency check measures the real figure. With only four ways, a set fills after four misses, and the fifth fill wraps the round-robin pointer. Short sequences can therefore show an eviction, a second eviction on the next way, and a neighbouring set that keeps its lines. The 12-bit tag lets the tests cover both tag zero, which matches invalid reset contents, and the all-ones tag.

// File: rtl/seqcache_pkg.sv
package seqcache_pkg;

    // Upper bound on associativity handled by the way encoder.
    localparam int unsigned MAX_WAYS = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_DATA,
        ST_FILL,
        ST_RESP
    } ctl_state_e;

    // Index of the lowest set bit; 0 when the vector is empty.
    function automatic int unsigned low_index(input logic [MAX_WAYS-1:0] vec);
        int unsigned idx;
        idx = 0;
        for (int i = MAX_WAYS - 1; i >= 0; i--) begin
            if (vec[i]) idx = i;
        end
        return idx;
    endfunction

    // Increment with wrap at lim.
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/seqcache_tags.sv
module seqcache_tags
    import seqcache_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 16,
    parameter int TAG_W = 21
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(SETS)-1:0]   lk_set,
    input  logic [TAG_W-1:0]          lk_tag,
    output logic                      hit,
    output logic [$clog2(WAYS)-1:0]   hit_way,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_set,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [TAG_W-1:0]          wr_tag
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  match;
    logic [MAX_WAYS-1:0] match_ext;

    // All ways of the selected set are compared side by side.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
    endgenerate

    always_comb begin
        match_ext = '0;
        match_ext[WAYS-1:0] = match;
    end

    assign hit     = |match;
    assign hit_way = WAY_W'(low_index(match_ext));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

endmodule

// File: rtl/seqcache_data.sv
module seqcache_data #(
    parameter int SETS   = 16,
    parameter int WAYS   = 16,
    parameter int LINE_W = 1024,
    parameter int LAT    = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    input  logic [$clog2(WAYS)-1:0]   rd_way,
    output logic                      rd_valid,
    output logic [LINE_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_set,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [LINE_W-1:0]         wr_data
);
    localparam int IDX_W   = $clog2(SETS) + $clog2(WAYS);
    localparam int ENTRIES = SETS * WAYS;

    logic [LINE_W-1:0] mem_q [ENTRIES];
    logic [LAT-1:0]    vld_q;
    logic [LINE_W-1:0] dat_q [LAT];
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;

    assign rd_idx = {rd_set, rd_way};
    assign wr_idx = {wr_set, wr_way};

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    // Only the addressed line is read; the pipeline models access latency.
    always_ff @(posedge clk) begin
        if (rd_en) dat_q[0] <= mem_q[rd_idx];
        for (int i = 1; i < LAT; i++) begin
            dat_q[i] <= dat_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= rd_en;
            for (int i = 1; i < LAT; i++) begin
                vld_q[i] <= vld_q[i-1];
            end
        end
    end

    assign rd_valid = vld_q[LAT-1];
    assign rd_data  = dat_q[LAT-1];

endmodule

// File: rtl/seqcache_rr.sv
module seqcache_rr
    import seqcache_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [$clog2(SETS)-1:0]   set_sel,
    output logic [$clog2(WAYS)-1:0]   victim,
    input  logic                      adv
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] ptr_q [SETS];

    assign victim = ptr_q[set_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (adv) begin
            ptr_q[set_sel] <= WAY_W'(wrap_inc(32'(ptr_q[set_sel]), WAYS));
        end
    end

endmodule

// File: rtl/seqcache_ctrl.sv
module seqcache_ctrl
    import seqcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int SETS       = 16,
    parameter int WAYS       = 16,
    parameter int DATA_LAT   = 5,
    parameter int CNT_W      = 32
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     req_valid,
    output logic                                     req_ready,
    input  logic [ADDR_W-1:0]                        req_addr,
    output logic                                     rsp_valid,
    output logic [LINE_BYTES*8-1:0]                  rsp_data,
    output logic                                     mem_req_valid,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     mem_req_addr,
    input  logic                                     fill_valid,
    input  logic [LINE_BYTES*8-1:0]                  fill_data,
    output logic [CNT_W-1:0]                         cnt_probe,
    output logic [CNT_W-1:0]                         cnt_data_rd,
    output logic [CNT_W-1:0]                         cnt_miss
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] set;
    } line_addr_t;

    ctl_state_e  st_q, st_d;
    line_addr_t  cur_q;
    logic [LINE_W-1:0] fill_q;

    logic accept, probe, tag_hit, probe_hit, probe_miss, fill_take;
    logic [WAY_W-1:0] hit_way, victim;
    logic rd_valid;
    logic [LINE_W-1:0] rd_data;
    logic offset_unused;

    assign offset_unused = ^req_addr[OFF_W-1:0];

    assign req_ready  = (st_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign probe      = (st_q == ST_PROBE);
    assign probe_hit  = probe && tag_hit;
    assign probe_miss = probe && !tag_hit;
    assign fill_take  = (st_q == ST_FILL) && fill_valid;

    seqcache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .lk_set  (cur_q.set),
        .lk_tag  (cur_q.tag),
        .hit     (tag_hit),
        .hit_way (hit_way),
        .wr_en   (fill_take),
        .wr_set  (cur_q.set),
        .wr_way  (victim),
        .wr_tag  (cur_q.tag)
    );

    seqcache_data #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .LAT(DATA_LAT)) u_data (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (probe_hit),
        .rd_set   (cur_q.set),
        .rd_way   (hit_way),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .wr_en    (fill_take),
        .wr_set   (cur_q.set),
        .wr_way   (victim),
        .wr_data  (fill_data)
    );

    seqcache_rr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .set_sel (cur_q.set),
        .victim  (victim),
        .adv     (fill_take)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept)     st_d = ST_PROBE;
            ST_PROBE: st_d = tag_hit ? ST_DATA : ST_FILL;
            ST_DATA:  if (rd_valid)   st_d = ST_IDLE;
            ST_FILL:  if (fill_valid) st_d = ST_RESP;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            fill_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept)    cur_q  <= line_addr_t'(req_addr[ADDR_W-1:OFF_W]);
            if (fill_take) fill_q <= fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_probe   <= '0;
            cnt_data_rd <= '0;
            cnt_miss    <= '0;
        end else begin
            if (probe)      cnt_probe   <= cnt_probe + 1'b1;
            if (probe_hit)  cnt_data_rd <= cnt_data_rd + 1'b1;
            if (probe_miss) cnt_miss    <= cnt_miss + 1'b1;
        end
    end

    // Miss leaves in the probe cycle itself.
    assign mem_req_valid = probe_miss;
    assign mem_req_addr  = cur_q;

    assign rsp_valid = ((st_q == ST_DATA) && rd_valid) || (st_q == ST_RESP);
    assign rsp_data  = (st_q == ST_RESP) ? fill_q : rd_data;

endmodule

// File: rtl/seqcache_ctrl_chk.sv
module seqcache_ctrl_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             mem_req_valid,
    input logic [CNT_W-1:0] cnt_probe,
    input logic [CNT_W-1:0] cnt_data_rd,
    input logic [CNT_W-1:0] cnt_miss
);

    // R2
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R2
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R3
    probe_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !rsp_valid);

    // R4
    miss_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R4
    miss_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> $past(req_valid && req_ready));

    // R4
    miss_skips_data_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> $stable(cnt_data_rd));

    // R9
    count_balance_chk: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(cnt_data_rd + cnt_miss) == cnt_probe);

endmodule

bind seqcache_ctrl seqcache_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_req_valid (mem_req_valid),
    .cnt_probe     (cnt_probe),
    .cnt_data_rd   (cnt_data_rd),
    .cnt_miss      (cnt_miss)
);

// File: tb/seqcache_ctrl_bench.sv
`timescale 1ns/1ps
module seqcache_ctrl_bench;
    localparam int ADDR_W = 16;
    localparam int LB     = 4;
    localparam int NSETS  = 4;
    localparam int NWAYS  = 4;
    localparam int LAT    = 5;
    localparam int CW     = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid;
    logic [31:0] rsp_data;
    logic mem_req_valid;
    logic [13:0] mem_req_addr;
    logic fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic [CW-1:0] cnt_probe, cnt_data_rd, cnt_miss;

    always #2 clk = ~clk;

    seqcache_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LB), .SETS(NSETS), .WAYS(NWAYS),
        .DATA_LAT(LAT), .CNT_W(CW)
    ) u_seqcache_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .cnt_probe(cnt_probe), .cnt_data_rd(cnt_data_rd), .cnt_miss(cnt_miss)
    );

    int checks = 0;
    int errors = 0;
    int probe_exp = 0;
    int miss_exp = 0;
    int hit_exp = 0;
    logic [31:0] exp_q [$];

    // Bench model of the stored lines and victim pointers.
    bit          m_vld [NSETS][NWAYS];
    logic [11:0] m_tag [NSETS][NWAYS];
    logic [31:0] m_dat [NSETS][NWAYS];
    int          m_ptr [NSETS];

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pops the scoreboard on each response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 R6 unexpected response", 64'(rsp_data), 64'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rsp_data == e, "R5 R6 response data", 64'(rsp_data), 64'(e));
            end
        end
    end

    task automatic lookup(input logic [11:0] tg, input logic [1:0] st, input bit exp_hit, input string lbl);
        logic [31:0] fd;
        logic [CW-1:0] rd0;
        int way;
        fd  = {8'h5A, 2'b00, st, 8'h00, tg};
        way = -1;
        for (int w = 0; w < NWAYS; w++)
            if (m_vld[st][w] && m_tag[st][w] == tg) way = w;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {tg, st, 2'b01};
        @(negedge clk);
        req_valid = 1'b0;
        probe_exp++;
        // probe cycle
        chk(req_ready == 1'b0, {lbl, " R2 busy after accept"}, 64'(req_ready), 64'd0);
        chk(rsp_valid == 1'b0, {lbl, " R3 no response in probe"}, 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == !exp_hit, {lbl, " R4 R5 miss forward"}, 64'(mem_req_valid), 64'(!exp_hit));
        rd0 = cnt_data_rd;
        if (!exp_hit) begin
            miss_exp++;
            chk(mem_req_addr == {tg, st}, {lbl, " R4 line address"}, 64'(mem_req_addr), 64'({tg, st}));
            @(negedge clk);
            chk(mem_req_valid == 1'b0, {lbl, " R4 single pulse"}, 64'(mem_req_valid), 64'd0);
            chk(cnt_miss == CW'(miss_exp), {lbl, " R4 miss count"}, 64'(cnt_miss), 64'(miss_exp));
            chk(cnt_data_rd == rd0, {lbl, " R4 no data read"}, 64'(cnt_data_rd), 64'(rd0));
            chk(cnt_probe == CW'(probe_exp), {lbl, " R3 probe count"}, 64'(cnt_probe), 64'(probe_exp));
            repeat (2) @(negedge clk);
            chk(req_ready == 1'b0 && rsp_valid == 1'b0, {lbl, " R2 waiting for fill"},
                64'({req_ready, rsp_valid}), 64'd0);
            exp_q.push_back(fd);
            fill_valid = 1'b1;
            fill_data  = fd;
            @(negedge clk);
            fill_valid = 1'b0;
            chk(rsp_valid == 1'b1, {lbl, " R6 response after fill"}, 64'(rsp_valid), 64'd1);
            chk(req_ready == 1'b0, {lbl, " R2 busy in response"}, 64'(req_ready), 64'd0);
            m_vld[st][m_ptr[st]] = 1'b1;
            m_tag[st][m_ptr[st]] = tg;
            m_dat[st][m_ptr[st]] = fd;
            m_ptr[st] = (m_ptr[st] + 1) % NWAYS;
            @(negedge clk);
            chk(req_ready == 1'b1, {lbl, " R2 ready after response"}, 64'(req_ready), 64'd1);
        end else begin
            hit_exp++;
            exp_q.push_back(way >= 0 ? m_dat[st][way] : 32'hDEAD_BEEF);
            @(negedge clk);
            chk(cnt_data_rd == CW'(hit_exp), {lbl, " R5 one data read"}, 64'(cnt_data_rd), 64'(hit_exp));
            repeat (LAT - 2) @(negedge clk);
            chk(rsp_valid == 1'b0, {lbl, " R5 not early"}, 64'(rsp_valid), 64'd0);
            @(negedge clk);
            chk(rsp_valid == 1'b1, {lbl, " R5 hit latency"}, 64'(rsp_valid), 64'd1);
            @(negedge clk);
            chk(req_ready == 1'b1 && rsp_valid == 1'b0, {lbl, " R2 ready after hit"},
                64'({req_ready, rsp_valid}), 64'h2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        report();
    end

    initial begin
        for (int s = 0; s < NSETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < NWAYS; w++) begin
                m_vld[s][w] = 1'b0;
                m_tag[s][w] = '0;
                m_dat[s][w] = '0;
            end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 strobes idle",
            64'({rsp_valid, mem_req_valid}), 64'd0);
        chk(cnt_probe == 0 && cnt_data_rd == 0 && cnt_miss == 0, "R1 counters zero",
            64'({cnt_probe, cnt_data_rd, cnt_miss}), 64'd0);

        lookup(12'h000, 2'd0, 1'b0, "R8 invalid tag zero");
        lookup(12'h000, 2'd0, 1'b1, "R6 refilled line");
        lookup(12'h001, 2'd0, 1'b0, "R6 fill way1");
        lookup(12'h002, 2'd0, 1'b0, "R6 fill way2");
        lookup(12'h003, 2'd0, 1'b0, "R6 fill way3");
        lookup(12'h003, 2'd0, 1'b1, "R5 hit way3");
        lookup(12'h001, 2'd0, 1'b1, "R5 hit way1");
        lookup(12'h002, 2'd0, 1'b1, "R5 hit way2");
        lookup(12'h005, 2'd1, 1'b0, "R10 other set fill");
        lookup(12'h000, 2'd0, 1'b1, "R10 set0 kept");
        lookup(12'h005, 2'd1, 1'b1, "R10 set1 hit");
        lookup(12'h004, 2'd0, 1'b0, "R7 fifth line");
        lookup(12'h000, 2'd0, 1'b0, "R7 first line evicted");
        lookup(12'h002, 2'd0, 1'b1, "R7 survivor");
        lookup(12'h004, 2'd0, 1'b1, "R7 new line hits");
        lookup(12'h001, 2'd0, 1'b0, "R7 second eviction");
        lookup(12'h003, 2'd0, 1'b1, "R7 way3 kept");
        lookup(12'hFFF, 2'd3, 1'b0, "R4 top tag miss");
        lookup(12'hFFF, 2'd3, 1'b1, "R5 top tag hit");
        lookup(12'h005, 2'd1, 1'b1, "R10 set1 still kept");

        repeat (2) @(negedge clk);
        chk(cnt_probe == CW'(probe_exp), "R3 total probes", 64'(cnt_probe), 64'(probe_exp));
        chk(cnt_miss == CW'(miss_exp), "R4 total misses", 64'(cnt_miss), 64'(miss_exp));
        chk(cnt_data_rd == CW'(hit_exp), "R9 data reads equal hits", 64'(cnt_data_rd), 64'(hit_exp));
        chk(CW'(cnt_data_rd + cnt_miss) == cnt_probe, "R9 counter balance",
            64'(cnt_data_rd + cnt_miss), 64'(cnt_probe));
        chk(exp_q.size() == 0, "R5 R6 all responses seen", 64'(exp_q.size()), 64'd0);
        report();
    end

endmodule